// File: doc/BRIEF.md
# Video Encoder Register Bank

This block is the byte-wide configuration store of a multi-standard composite video encoder. A host writes it over an 8-bit data bus, qualified by an active-low select and an active-low write strobe that need not share the encoder's 27 MHz clock. The strobe and select are brought into the clock domain. A falling edge of the resynchronised strobe with select low commits one byte to the addressed register. The readback bus is a pure function of the address and the stored contents.

Downstream, the video datapath sees decoded parameter outputs rather than raw bytes. Wide values are assembled from a low byte and a few high bits held in the next location. When the auto bit is set, every timing and level parameter is replaced by a built-in default for the selected standard. The two control bytes and the pre-emphasis byte keep driving their outputs in both modes. The luma pedestal is forced to zero on the two standards that carry no setup.

Top module: `vencRegBank`

## Requirements
- R1: A register is written when the write strobe goes low while select is low. The new value is visible on readback no later than three clock edges after the low strobe is first sampled. A single low pulse writes exactly once: a data change later in the same pulse is not stored.
- R2: A strobe pulse with select held high changes no register.
- R3: The readback bus always shows the addressed register, whatever the state of select and strobe. Unused addresses 13 to 15 read zero. Unimplemented high bits of the high-byte registers read zero: address 4 and address 6 keep bits [2:0], address 8 keeps bits [1:0], and address 10 keeps bit 0.
- R4: After reset every register and every parameter output is zero.
- R5: In manual mode the parameters are assembled from the register map as follows:
  - broadWidth = {reg4[2:0], reg3}
  - syncWidth = {reg6[2:0], reg5}
  - lumaScale = {reg8[1:0], reg7}
  - outGain = {reg10[0], reg9}
  - pedestal = reg11
  - lumaOffset = reg12
- R6: When reg1 bit 7 is set (auto mode), the parameters take fixed defaults for the selected standard, listed as broad/sync/luma/gain/pedestal/offset:
  - NTSC-M: 1450/127/600/300/42/16
  - PAL: 1480/126/580/290/0/16
  - PAL-M: 1452/125/596/296/40/18
  - PAL-N: 1482/128/584/292/0/20
- R7: ctrlMisc = reg0, autoMode = reg1[7], videoStd = reg1[5:4] and preEmph = reg2 follow the programmed values in both modes.
- R8: videoStd encoding: 00 NTSC-M, 01 PAL, 10 PAL-M, 11 PAL-N.
- R9: pedestal is zero whenever PAL (01) or PAL-N (11) is selected, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz encoder clock |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Active-low select |
| wrN | input | 1 | Active-low write strobe |
| addr | input | 4 | Register address for write and readback |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Contents of addressed register |
| ctrlMisc | output | 8 | Control byte 0 |
| autoMode | output | 1 | Auto-defaults enable |
| videoStd | output | 2 | Selected standard |
| preEmph | output | 8 | Pre-emphasis setting |
| broadWidth | output | 11 | Effective broad pulse width |
| syncWidth | output | 11 | Effective sync pulse width |
| lumaScale | output | 10 | Effective luma scale |
| outGain | output | 9 | Effective composite gain |
| pedestal | output | 8 | Effective luma pedestal |
| lumaOffset | output | 8 | Effective luma offset |

## Verification
The bench builds the block with its defaults: a 4-bit address, 13 registers and a two-stage strobe synchroniser. With these values the whole address space, including the three unused locations, is reachable by random writes and reads. The three-edge write latency is also short enough to test a data change inside a long strobe pulse. Every standard is visited in both manual and auto mode, so the default table and the pedestal suppression are exercised for all four codes.

// File: rtl/vencRegPkg.sv
package vencRegPkg;
  parameter int ADDR_W   = 4;
  parameter int DATA_W   = 8;
  parameter int NUM_REGS = 13;

  localparam int BROAD_W = 11;
  localparam int SYNC_W  = 11;
  localparam int LUMA_W  = 10;
  localparam int GAIN_W  = 9;
  localparam int PED_W   = 8;
  localparam int OFF_W   = 8;

  localparam int IDX_CTRL0  = 0;
  localparam int IDX_CTRL1  = 1;
  localparam int IDX_PREEMP = 2;
  localparam int IDX_BRD_LO = 3;
  localparam int IDX_BRD_HI = 4;
  localparam int IDX_SYN_LO = 5;
  localparam int IDX_SYN_HI = 6;
  localparam int IDX_LUM_LO = 7;
  localparam int IDX_LUM_HI = 8;
  localparam int IDX_GAN_LO = 9;
  localparam int IDX_GAN_HI = 10;
  localparam int IDX_PED    = 11;
  localparam int IDX_OFF    = 12;

  localparam int AUTO_BIT = 7;
  localparam int STD_LSB  = 4;

  typedef enum logic [1:0] {
    STD_NTSC_M = 2'b00,
    STD_PAL    = 2'b01,
    STD_PAL_M  = 2'b10,
    STD_PAL_N  = 2'b11
  } videoStdE;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
  } wrStrobeS;

  typedef struct packed {
    logic [BROAD_W-1:0] broad;
    logic [SYNC_W-1:0]  sync;
    logic [LUMA_W-1:0]  luma;
    logic [GAIN_W-1:0]  gain;
    logic [PED_W-1:0]   ped;
    logic [OFF_W-1:0]   offset;
  } vidParamS;

  function automatic logic [DATA_W-1:0] regMask(input int idx);
    case (idx)
      IDX_BRD_HI: regMask = DATA_W'((1 << (BROAD_W - DATA_W)) - 1);
      IDX_SYN_HI: regMask = DATA_W'((1 << (SYNC_W - DATA_W)) - 1);
      IDX_LUM_HI: regMask = DATA_W'((1 << (LUMA_W - DATA_W)) - 1);
      IDX_GAN_HI: regMask = DATA_W'((1 << (GAIN_W - DATA_W)) - 1);
      default:    regMask = '1;
    endcase
  endfunction

  function automatic vidParamS stdDefaults(input videoStdE s);
    vidParamS p;
    case (s)
      STD_NTSC_M: begin
        p.broad = 11'd1450; p.sync = 11'd127; p.luma = 10'd600;
        p.gain = 9'd300; p.ped = 8'd42; p.offset = 8'd16;
      end
      STD_PAL: begin
        p.broad = 11'd1480; p.sync = 11'd126; p.luma = 10'd580;
        p.gain = 9'd290; p.ped = 8'd0; p.offset = 8'd16;
      end
      STD_PAL_M: begin
        p.broad = 11'd1452; p.sync = 11'd125; p.luma = 10'd596;
        p.gain = 9'd296; p.ped = 8'd40; p.offset = 8'd18;
      end
      default: begin
        p.broad = 11'd1482; p.sync = 11'd128; p.luma = 10'd584;
        p.gain = 9'd292; p.ped = 8'd0; p.offset = 8'd20;
      end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/vencRegCtrl.sv
module vencRegCtrl
  import vencRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output wrStrobeS          wrBus
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] wrSync;
  logic [SYNC_STAGES-1:0] csSync;
  logic                   wrPrev;

  // Resynchroniser chains, one stage per generate iteration.
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            wrSync[0] <= 1'b1;
            csSync[0] <= 1'b1;
          end else begin
            wrSync[0] <= wrN;
            csSync[0] <= csN;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            wrSync[g] <= 1'b1;
            csSync[g] <= 1'b1;
          end else begin
            wrSync[g] <= wrSync[g-1];
            csSync[g] <= csSync[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPrev <= 1'b1;
    else       wrPrev <= wrSync[LAST];
  end

  always_comb begin
    wrBus.wrEn   = wrPrev & ~wrSync[LAST] & ~csSync[LAST];
    wrBus.wrAddr = addr;
    wrBus.wrData = wrData;
  end
endmodule

// File: rtl/vencRegData.sv
module vencRegData
  import vencRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobeS          wrBus,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ctrlMisc,
  output logic              autoMode,
  output logic [1:0]        videoStd,
  output logic [DATA_W-1:0] preEmph,
  output vidParamS          params
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  vidParamS progP;
  vidParamS defP;
  vidParamS selP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wrBus.wrEn) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wrBus.wrAddr == ADDR_W'(i))
          regs[i] <= wrBus.wrData & regMask(i);
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) rdData = regs[i];
  end

  assign ctrlMisc = regs[IDX_CTRL0];
  assign autoMode = regs[IDX_CTRL1][AUTO_BIT];
  assign videoStd = regs[IDX_CTRL1][STD_LSB+1:STD_LSB];
  assign preEmph  = regs[IDX_PREEMP];

  always_comb begin
    progP.broad  = {regs[IDX_BRD_HI][BROAD_W-DATA_W-1:0], regs[IDX_BRD_LO]};
    progP.sync   = {regs[IDX_SYN_HI][SYNC_W-DATA_W-1:0], regs[IDX_SYN_LO]};
    progP.luma   = {regs[IDX_LUM_HI][LUMA_W-DATA_W-1:0], regs[IDX_LUM_LO]};
    progP.gain   = {regs[IDX_GAN_HI][GAIN_W-DATA_W-1:0], regs[IDX_GAN_LO]};
    progP.ped    = regs[IDX_PED];
    progP.offset = regs[IDX_OFF];
    defP = stdDefaults(videoStdE'(videoStd));
    selP = autoMode ? defP : progP;
    params = selP;
    if (videoStd == STD_PAL || videoStd == STD_PAL_N) params.ped = '0;
  end
endmodule

// File: rtl/vencRegBank.sv
module vencRegBank
  import vencRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               wrN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [DATA_W-1:0]  ctrlMisc,
  output logic               autoMode,
  output logic [1:0]         videoStd,
  output logic [DATA_W-1:0]  preEmph,
  output logic [BROAD_W-1:0] broadWidth,
  output logic [SYNC_W-1:0]  syncWidth,
  output logic [LUMA_W-1:0]  lumaScale,
  output logic [GAIN_W-1:0]  outGain,
  output logic [PED_W-1:0]   pedestal,
  output logic [OFF_W-1:0]   lumaOffset
);
  wrStrobeS ctrlBus;
  vidParamS effP;

  vencRegCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN),
    .addr(addr), .wrData(wrData), .wrBus(ctrlBus)
  );

  vencRegData u_data (
    .clk(clk), .rstN(rstN), .wrBus(ctrlBus), .addr(addr),
    .rdData(rdData), .ctrlMisc(ctrlMisc), .autoMode(autoMode),
    .videoStd(videoStd), .preEmph(preEmph), .params(effP)
  );

  assign broadWidth = effP.broad;
  assign syncWidth  = effP.sync;
  assign lumaScale  = effP.luma;
  assign outGain    = effP.gain;
  assign pedestal   = effP.ped;
  assign lumaOffset = effP.offset;
endmodule

// File: rtl/vencRegChecker.sv
module vencRegChecker
  import vencRegPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input wrStrobeS           wrBus,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  rdData,
  input logic               autoMode,
  input logic [1:0]         videoStd,
  input logic [DATA_W-1:0]  preEmph,
  input logic [BROAD_W-1:0] broadWidth,
  input logic [SYNC_W-1:0]  syncWidth,
  input logic [LUMA_W-1:0]  lumaScale,
  input logic [GAIN_W-1:0]  outGain,
  input logic [PED_W-1:0]   pedestal,
  input logic [OFF_W-1:0]   lumaOffset
);
  assert_single_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    wrBus.wrEn |=> !wrBus.wrEn);

  assert_rd_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(addr) && !$past(wrBus.wrEn)) |-> $stable(rdData));

  assert_auto_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && $past(autoMode) && $stable(videoStd)) |->
      ($stable(broadWidth) && $stable(syncWidth) && $stable(lumaScale) &&
       $stable(outGain) && $stable(pedestal) && $stable(lumaOffset)));

  assert_preemph_live_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrBus.wrEn && wrBus.wrAddr == ADDR_W'(IDX_PREEMP)) |=>
      (preEmph == $past(wrBus.wrData)));

  assert_no_pedestal_R9: assert property (@(posedge clk) disable iff (!rstN)
    videoStd[0] |-> (pedestal == '0));
endmodule

bind vencRegBank vencRegChecker u_chk (
  .clk(clk), .rstN(rstN), .wrBus(ctrlBus), .addr(addr), .rdData(rdData),
  .autoMode(autoMode), .videoStd(videoStd), .preEmph(preEmph),
  .broadWidth(broadWidth), .syncWidth(syncWidth), .lumaScale(lumaScale),
  .outGain(outGain), .pedestal(pedestal), .lumaOffset(lumaOffset)
);

// File: tb/vencRegBank_bench.sv
`timescale 1ns/1ps
module vencRegBank_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic wrN = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, ctrlMisc, preEmph, pedestal, lumaOffset;
  logic autoMode;
  logic [1:0] videoStd;
  logic [10:0] broadWidth, syncWidth;
  logic [9:0] lumaScale;
  logic [8:0] outGain;

  int tests = 0;
  int fails = 0;
  logic [7:0] shadow [16];

  always #2.5 clk = ~clk;

  vencRegBank u_vencRegBank (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ctrlMisc(ctrlMisc),
    .autoMode(autoMode), .videoStd(videoStd), .preEmph(preEmph),
    .broadWidth(broadWidth), .syncWidth(syncWidth), .lumaScale(lumaScale),
    .outGain(outGain), .pedestal(pedestal), .lumaOffset(lumaOffset)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] maskOf(input int a);
    case (a)
      4, 6: return 8'h07;
      8: return 8'h03;
      10: return 8'h01;
      13, 14, 15: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  // Default table from R6, indexed by the R8 standard code.
  function automatic logic [63:0] dflt(input logic [1:0] s, input int f);
    int t [4][6] = '{'{1450,127,600,300,42,16}, '{1480,126,580,290,0,16},
                     '{1452,125,596,296,40,18}, '{1482,128,584,292,0,20}};
    return 64'(t[s][f]);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    addr = a; wrData = d; csN = ~sel;
    cyc(1);
    wrN = 1'b0;
    cyc(4);
    wrN = 1'b1;
    cyc(1);
    csN = 1'b1;
    cyc(4);
    if (sel) shadow[a] = d & maskOf(a);
  endtask

  task automatic readCheck(input logic [3:0] a, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdData, shadow[a]);
  endtask

  task automatic checkOutputs(input string tag);
    logic [1:0] s;
    logic au;
    logic [31:0] eb, es, el, eg, ep, eo;
    s = shadow[1][5:4];
    au = shadow[1][7];
    if (au) begin
      eb = 32'(dflt(s,0)); es = 32'(dflt(s,1)); el = 32'(dflt(s,2));
      eg = 32'(dflt(s,3)); ep = 32'(dflt(s,4)); eo = 32'(dflt(s,5));
    end else begin
      eb = {21'd0, shadow[4][2:0], shadow[3]};
      es = {21'd0, shadow[6][2:0], shadow[5]};
      el = {22'd0, shadow[8][1:0], shadow[7]};
      eg = {23'd0, shadow[10][0], shadow[9]};
      ep = {24'd0, shadow[11]};
      eo = {24'd0, shadow[12]};
    end
    if (s[0]) ep = 0;
    #1;
    check({tag, " R7 ctrlMisc"}, ctrlMisc, shadow[0]);
    check({tag, " R7 autoMode"}, autoMode, au);
    check({tag, " R8 videoStd"}, videoStd, s);
    check({tag, " R7 preEmph"}, preEmph, shadow[2]);
    check({tag, " R5/R6 broadWidth"}, broadWidth, eb);
    check({tag, " R5/R6 syncWidth"}, syncWidth, es);
    check({tag, " R5/R6 lumaScale"}, lumaScale, el);
    check({tag, " R5/R6 outGain"}, outGain, eg);
    check({tag, " R9 pedestal"}, pedestal, ep);
    check({tag, " R5/R6 lumaOffset"}, lumaOffset, eo);
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    // R4: reset state
    for (int i = 0; i < 16; i++) readCheck(4'(i), "R4 reset readback");
    checkOutputs("R4 reset");

    // R1: write latency of three edges
    @(negedge clk);
    addr = 4'd0; wrData = 8'hA5; csN = 1'b0;
    cyc(1);
    wrN = 1'b0;
    cyc(3);
    #1;
    check("R1 latency", rdData, 8'hA5);
    // R1: data change inside the same pulse is not stored
    wrData = 8'h3C;
    cyc(4);
    #1;
    check("R1 single write", rdData, 8'hA5);
    wrN = 1'b1;
    cyc(1);
    csN = 1'b1;
    cyc(4);
    shadow[0] = 8'hA5;
    readCheck(4'd0, "R1 after pulse");

    // R2: select high blocks the write
    writeReg(4'd2, 8'h77, 1'b0);
    readCheck(4'd2, "R2 cs high");
    checkOutputs("R2");

    // R3: readback independent of strobes, masked bits, unused addresses
    writeReg(4'd4, 8'hFF, 1'b1);
    @(negedge clk);
    addr = 4'd4; csN = 1'b0; wrN = 1'b1;
    #1 check("R3 masked hi, cs low", rdData, 8'h07);
    csN = 1'b1;
    #1 check("R3 masked hi, cs high", rdData, 8'h07);
    writeReg(4'd14, 8'hEE, 1'b1);
    readCheck(4'd14, "R3 unused address");
    writeReg(4'd10, 8'hFF, 1'b1);
    readCheck(4'd10, "R3 gain hi mask");

    // R5 manual with each standard; R6 auto with each standard; R9
    writeReg(4'd3, 8'h12, 1'b1);
    writeReg(4'd7, 8'hF0, 1'b1);
    writeReg(4'd8, 8'h02, 1'b1);
    writeReg(4'd11, 8'h33, 1'b1);
    writeReg(4'd12, 8'h44, 1'b1);
    for (int s = 0; s < 4; s++) begin
      writeReg(4'd1, {2'b00, 2'(s), 4'h0}, 1'b1);
      checkOutputs("R5 manual");
      writeReg(4'd1, {2'b10, 2'(s), 4'h5}, 1'b1);
      checkOutputs("R6 auto");
      // R7: pre-emphasis stays live in auto mode
      writeReg(4'd2, 8'(8'h10 + s), 1'b1);
      writeReg(4'd9, 8'h5A, 1'b1);
      checkOutputs("R7 auto live");
    end

    // Random mix
    for (int n = 0; n < 200; n++) begin
      logic [3:0] a;
      logic [7:0] d;
      logic sel;
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      sel = ($urandom_range(0, 9) != 0);
      writeReg(a, d, sel);
      readCheck(a, "R1/R2/R3 random");
      if (n % 10 == 0) checkOutputs("R5/R6 random");
    end

    // R4: reset again clears everything
    rstN = 1'b0;
    cyc(2);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    cyc(2);
    checkOutputs("R4 re-reset");
    readCheck(4'd1, "R4 re-reset readback");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule